// File: doc/BRIEF.md
# Serial Link to Byte-Parallel Adaptor

This block joins a pair of point-to-point serial wires, one carrying data in and one carrying data out, to an 8-bit parallel port on the local side. Bytes written on the parallel side are wrapped in a data frame and shifted out. Bytes that arrive on the serial input are unwrapped and offered on the parallel side. Each direction runs on its own wire, so both can move data at the same time.

Every data byte is answered with a short acknowledge frame, and the transmitter does not start a new byte until the acknowledge for its previous byte has come back. This lets a slow node and a fast node share a link without losing data. The receiver can answer as soon as it has recognised the header of an incoming byte, so a sender does not have to pause between bytes. The serial input is asynchronous to the local clock: it is brought in through synchroniser flops and sampled at a fixed multiple of the bit rate, with the sample point set from the leading edge of each frame.

A mode input chooses between two separate one-way parallel ports and a single shared port whose drive direction is set by a direction input. In shared mode the data pads are exposed as separate in, out and enable signals, so the tristate buffers can sit in the pad ring.

Top module: `serial_link_adaptor`

## Requirements
- R1: While reset is high and in the first cycle after it falls, `link_out` is low, `rd_valid` is low and `pad_oe` is low. In separate-port mode `wr_ready` is high right after reset, because one transmit credit is held.
- R2: A byte accepted on the parallel side goes out on `link_out` as high, high, then data bits 0 through 7 (bit 0 first), then a low stop bit. Each bit lasts OVS clock cycles, and the line rests low between frames.
- R3: A data frame of the same format on `link_in`, with any phase relative to the local clock, is presented on `rd_data` with `rd_valid` high. Bytes are presented in arrival order, and each one is removed by `rd_take`.
- R4: For an incoming data byte that finds the receive buffer empty, an acknowledge frame (a high bit, then a low bit) starts on `link_out` within 30 clock cycles of the incoming start bit. With OVS = 4 the incoming frame itself lasts 44 cycles, so the acknowledge begins well before it ends.
- R5: After a byte is accepted, `wr_ready` stays low until an acknowledge frame has been received on `link_in`.
- R6: When an acknowledge is owed and a data byte is also waiting at a frame boundary, the acknowledge frame is sent first.
- R7: A received frame whose stop bit is high is thrown away. `rd_valid` stays low for it, and `frame_err` pulses high for one cycle.
- R8: While one unread byte sits in the buffer, the acknowledge for a second incoming byte is withheld. When the first byte is taken, the second byte is presented and its acknowledge is sent.
- R9: In shared mode (`bidir_mode` = 1) with `dir_out` = 0, transmit data comes from `pad_i`, and `pad_oe` and `rd_valid` are low. With `dir_out` = 1, `pad_oe` is high, `pad_o` shows the received byte, `rd_valid` reflects the buffer, and `wr_ready` is low.
- R10: When `link_out` is looped back to `link_in`, a stream of bytes written one after another all arrive in order, and each byte's transmit credit returns through the loop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock, OVS times the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| link_in | input | 1 | Serial input, asynchronous to clk |
| link_out | output | 1 | Serial output, registered |
| bidir_mode | input | 1 | 0: separate ports, 1: shared port |
| dir_out | input | 1 | Shared mode: 1 drives received bytes out, 0 takes bytes to send |
| wr_data | input | 8 | Byte to send in separate-port mode |
| wr_valid | input | 1 | A byte to send is offered |
| wr_ready | output | 1 | The offered byte is accepted on this cycle's edge |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | A received byte is available |
| rd_take | input | 1 | Removes the available byte |
| pad_i | input | 8 | Shared-port pad input, the byte source in shared mode |
| pad_o | output | 8 | Shared-port pad output value |
| pad_oe | output | 1 | Shared-port pad output enable |
| frame_err | output | 1 | One-cycle pulse on a frame with a bad stop bit |

## Verification
A lost or doubled acknowledge appears at the ports within one frame time. Either `wr_ready` never comes back after a byte is sent, or an extra two-bit frame shows up on `link_out` between data frames. A wrong sample point or a wrong bit counter corrupts the next byte delivered on `rd_data`, or raises `frame_err` at the stop bit of that same frame. A bad buffer or owed-acknowledge state shows up when the reader stalls. Either an acknowledge leaks out while a byte is still unread, or the second byte never appears once the first is taken.

// File: rtl/sla_pkg.sv
package sla_pkg;
  timeunit 1ns; timeprecision 100ps;

  // bits a data frame adds around the payload: two header bits, one stop bit
  localparam int unsigned FRAME_EXTRA = 3;
  localparam int unsigned ACK_LEN     = 2;

  typedef enum logic [1:0] {RX_IDLE, RX_FLAG, RX_DATA, RX_STOP} rx_state_e;
  typedef enum logic       {TX_IDLE, TX_SEND} tx_state_e;
endpackage

// File: rtl/sla_sync.sv
module sla_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  timeunit 1ns; timeprecision 100ps;

  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/sla_rx.sv
module sla_rx
  import sla_pkg::*;
#(
  parameter int OVS = 4,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          line,
  output logic          hdr,
  output logic          done,
  output logic          err,
  output logic          ack_seen,
  output logic [DW-1:0] byte_q
);
  timeunit 1ns; timeprecision 100ps;

  localparam int CW = $clog2(OVS + OVS/2);
  localparam int BW = $clog2(DW);
  // the rise is seen one cycle after the synchronised line went high;
  // the counter puts the next sample in the middle of the second bit
  localparam int FIRST_WAIT = OVS + OVS/2 - 2;

  rx_state_e      st;
  logic [CW-1:0]  cnt;
  logic [BW-1:0]  idx;
  logic           prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= RX_IDLE;
      cnt      <= '0;
      idx      <= '0;
      prev     <= 1'b0;
      hdr      <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      ack_seen <= 1'b0;
      byte_q   <= '0;
    end else begin
      hdr      <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      ack_seen <= 1'b0;
      prev     <= line;
      unique case (st)
        RX_IDLE: begin
          if (line && !prev) begin
            st  <= RX_FLAG;
            cnt <= CW'(FIRST_WAIT);
          end
        end
        RX_FLAG: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else if (line) begin
            st  <= RX_DATA;
            cnt <= CW'(OVS - 1);
            idx <= '0;
            hdr <= 1'b1;
          end else begin
            st       <= RX_IDLE;
            ack_seen <= 1'b1;
          end
        end
        RX_DATA: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else begin
            byte_q <= {line, byte_q[DW-1:1]};
            cnt    <= CW'(OVS - 1);
            if (idx == BW'(DW - 1)) st  <= RX_STOP;
            else                    idx <= idx + 1'b1;
          end
        end
        RX_STOP: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else begin
            st <= RX_IDLE;
            if (!line) done <= 1'b1;
            else       err  <= 1'b1;
          end
        end
        default: st <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sla_rxbuf.sv
module sla_rxbuf #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hdr,
  input  logic          done,
  input  logic          err,
  input  logic [DW-1:0] byte_in,
  input  logic          take,
  output logic          full,
  output logic [DW-1:0] data,
  output logic          ack_req
);
  timeunit 1ns; timeprecision 100ps;

  logic          hold;
  logic [DW-1:0] hold_q;
  logic          owed;
  logic          free;

  assign free = !full || take;

  always_ff @(posedge clk) begin
    if (rst) begin
      full    <= 1'b0;
      data    <= '0;
      hold    <= 1'b0;
      hold_q  <= '0;
      owed    <= 1'b0;
      ack_req <= 1'b0;
    end else begin
      ack_req <= 1'b0;
      if (take && full) full <= 1'b0;
      // header: answer at once only if the byte is sure to find room
      if (hdr) begin
        if (!full) ack_req <= 1'b1;
        owed <= full;
      end
      if (done) begin
        if (free) begin
          data <= byte_in;
          full <= 1'b1;
          if (owed) begin
            ack_req <= 1'b1;
            owed    <= 1'b0;
          end
        end else begin
          hold   <= 1'b1;
          hold_q <= byte_in;
        end
      end
      // a discarded frame still settles its debt so the link keeps moving
      if (err && owed) begin
        ack_req <= 1'b1;
        owed    <= 1'b0;
      end
      if (hold && free) begin
        data <= hold_q;
        full <= 1'b1;
        hold <= 1'b0;
        if (owed) begin
          ack_req <= 1'b1;
          owed    <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/sla_tx.sv
module sla_tx
  import sla_pkg::*;
#(
  parameter int OVS = 4,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ack_req,
  input  logic          ack_seen,
  input  logic          load,
  input  logic [DW-1:0] din,
  output logic          line,
  output logic          slot_free,
  output logic          credit,
  output logic          ack_pend
);
  timeunit 1ns; timeprecision 100ps;

  localparam int FL = DW + FRAME_EXTRA;
  localparam int LW = $clog2(FL);
  localparam int CW = $clog2(OVS);

  tx_state_e      st;
  logic [FL-1:0]  sh;
  logic [LW-1:0]  left;
  logic [CW-1:0]  cnt;
  logic           last;
  logic           start_ack;
  logic           start_dat;

  assign last      = (st == TX_SEND) && (cnt == '0) && (left == '0);
  assign slot_free = (st == TX_IDLE) || last;
  assign start_ack = slot_free && ack_pend;
  assign start_dat = slot_free && !ack_pend && load;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= TX_IDLE;
      sh       <= '0;
      left     <= '0;
      cnt      <= '0;
      line     <= 1'b0;
      credit   <= 1'b1;
      ack_pend <= 1'b0;
    end else begin
      if (ack_req)        ack_pend <= 1'b1;
      else if (start_ack) ack_pend <= 1'b0;

      if (ack_seen)       credit <= 1'b1;
      else if (start_dat) credit <= 1'b0;

      if (start_ack) begin
        line <= 1'b1;
        sh   <= '0;
        left <= LW'(ACK_LEN - 1);
        cnt  <= CW'(OVS - 1);
        st   <= TX_SEND;
      end else if (start_dat) begin
        line <= 1'b1;
        sh   <= FL'({1'b0, din, 1'b1});
        left <= LW'(FL - 1);
        cnt  <= CW'(OVS - 1);
        st   <= TX_SEND;
      end else if (st == TX_SEND) begin
        if (cnt != '0) begin
          cnt <= cnt - 1'b1;
        end else if (left != '0) begin
          line <= sh[0];
          sh   <= sh >> 1;
          left <= left - 1'b1;
          cnt  <= CW'(OVS - 1);
        end else begin
          line <= 1'b0;
          st   <= TX_IDLE;
        end
      end
    end
  end
endmodule

// File: rtl/serial_link_adaptor.sv
module serial_link_adaptor
  import sla_pkg::*;
#(
  parameter int OVS  = 4,
  parameter int DW   = 8,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          link_in,
  output logic          link_out,
  input  logic          bidir_mode,
  input  logic          dir_out,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_valid,
  output logic          wr_ready,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  input  logic          rd_take,
  input  logic [DW-1:0] pad_i,
  output logic [DW-1:0] pad_o,
  output logic          pad_oe,
  output logic          frame_err
);
  timeunit 1ns; timeprecision 100ps;

  logic          line_s;
  logic          rx_hdr, rx_done, rx_err, ack_seen;
  logic [DW-1:0] rx_byte;
  logic          buf_full, ack_req, take;
  logic [DW-1:0] buf_data;
  logic          slot_free, credit, ack_pend;
  logic          accept;
  logic [DW-1:0] tx_byte;
  logic          wr_side_ok, rd_side_ok;

  sla_sync #(.STAGES(SYNC)) u_sync (
    .clk(clk), .rst(rst), .din(link_in), .dout(line_s)
  );

  sla_rx #(.OVS(OVS), .DW(DW)) u_rx (
    .clk(clk), .rst(rst), .line(line_s),
    .hdr(rx_hdr), .done(rx_done), .err(rx_err),
    .ack_seen(ack_seen), .byte_q(rx_byte)
  );

  sla_rxbuf #(.DW(DW)) u_buf (
    .clk(clk), .rst(rst), .hdr(rx_hdr), .done(rx_done), .err(rx_err),
    .byte_in(rx_byte), .take(take),
    .full(buf_full), .data(buf_data), .ack_req(ack_req)
  );

  sla_tx #(.OVS(OVS), .DW(DW)) u_tx (
    .clk(clk), .rst(rst), .ack_req(ack_req), .ack_seen(ack_seen),
    .load(accept), .din(tx_byte), .line(link_out),
    .slot_free(slot_free), .credit(credit), .ack_pend(ack_pend)
  );

  // port mode steering
  assign wr_side_ok = !bidir_mode || !dir_out;
  assign rd_side_ok = !bidir_mode || dir_out;

  assign wr_ready  = slot_free && credit && !ack_pend && wr_side_ok;
  assign accept    = wr_valid && wr_ready;
  assign tx_byte   = bidir_mode ? pad_i : wr_data;

  assign rd_valid  = buf_full && rd_side_ok;
  assign take      = rd_take && rd_valid;
  assign rd_data   = buf_data;
  assign pad_o     = bidir_mode ? buf_data : '0;
  assign pad_oe    = bidir_mode && dir_out;
  assign frame_err = rx_err;
endmodule

// File: rtl/serial_link_adaptor_chk.sv
module serial_link_adaptor_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          ack_req,
  input logic          ack_pend,
  input logic          accept,
  input logic          wr_ready,
  input logic          buf_full,
  input logic          take,
  input logic [DW-1:0] buf_data,
  input logic          bidir_mode,
  input logic          dir_out,
  input logic          rd_valid,
  input logic          pad_oe,
  input logic          link_out
);
  timeunit 1ns; timeprecision 100ps;

  assert_quiet_after_reset_R1: assert property (@(posedge clk)
    $fell(rst) |-> !link_out && !rd_valid && !pad_oe);

  assert_ack_not_dropped_R4: assert property (@(posedge clk) disable iff (rst)
    ack_req |-> !ack_pend);

  assert_one_byte_per_ack_R5: assert property (@(posedge clk) disable iff (rst)
    accept |=> !wr_ready);

  assert_buffer_held_R8: assert property (@(posedge clk) disable iff (rst)
    (buf_full && !take) |=> buf_full && $stable(buf_data));

  assert_shared_port_inbound_R9: assert property (@(posedge clk) disable iff (rst)
    (bidir_mode && !dir_out) |-> !rd_valid && !pad_oe);
endmodule

bind serial_link_adaptor serial_link_adaptor_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .ack_req(ack_req), .ack_pend(ack_pend),
  .accept(accept), .wr_ready(wr_ready), .buf_full(buf_full), .take(take),
  .buf_data(buf_data), .bidir_mode(bidir_mode), .dir_out(dir_out),
  .rd_valid(rd_valid), .pad_oe(pad_oe), .link_out(link_out)
);

// File: tb/serial_link_adaptor_tb.sv
module serial_link_adaptor_tb;
  timeunit 1ns; timeprecision 100ps;

  localparam int    OVS   = 4;
  localparam int    DW    = 8;
  localparam real   BITNS = 16.0;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          link_in, link_out;
  logic          bidir_mode = 1'b0, dir_out = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          wr_valid = 1'b0;
  logic          wr_ready;
  logic [DW-1:0] rd_data;
  logic          rd_valid;
  logic          rd_take = 1'b1;
  logic [DW-1:0] pad_i = '0;
  logic [DW-1:0] pad_o;
  logic          pad_oe;
  logic          frame_err;

  logic drv_line = 1'b0;
  logic loop_en  = 1'b0;
  logic loop_d   = 1'b0;
  int   nchk = 0, nfail = 0, cyc = 0, err_seen = 0;
  logic [DW-1:0] exp_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(link_out) loop_d <= #1.5 link_out;
  assign link_in = loop_en ? loop_d : drv_line;

  serial_link_adaptor #(.OVS(OVS), .DW(DW), .SYNC(2)) u_dut (
    .clk(clk), .rst(rst), .link_in(link_in), .link_out(link_out),
    .bidir_mode(bidir_mode), .dir_out(dir_out),
    .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_take(rd_take),
    .pad_i(pad_i), .pad_o(pad_o), .pad_oe(pad_oe), .frame_err(frame_err)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  // scoreboard monitor: every byte leaving the buffer must match the queue head
  always @(negedge clk) begin
    if (!rst && frame_err) err_seen++;
    if (!rst && rd_valid && rd_take) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R3 unexpected byte", int'(rd_data), 0);
      end else begin
        logic [DW-1:0] e;
        e = exp_q.pop_front();
        check(rd_data == e, "R3 received byte", int'(rd_data), int'(e));
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send_frame(input logic [DW-1:0] d, input bit bad_stop, input real ph);
    #(ph);
    drv_line = 1'b1; #(BITNS);
    drv_line = 1'b1; #(BITNS);
    for (int i = 0; i < DW; i++) begin
      drv_line = d[i]; #(BITNS);
    end
    drv_line = bad_stop; #(BITNS);
    drv_line = 1'b0;
  endtask

  task automatic send_ack();
    drv_line = 1'b1; #(BITNS);
    drv_line = 1'b0; #(BITNS);
  endtask

  // decode one frame from link_out, sampling once per bit period
  task automatic grab(output bit is_data, output logic [DW-1:0] d, output bit bad);
    d = '0; bad = 1'b0; is_data = 1'b0;
    do @(negedge clk); while (link_out !== 1'b1);
    repeat (OVS) @(negedge clk);
    if (link_out !== 1'b1) return;
    is_data = 1'b1;
    for (int i = 0; i < DW; i++) begin
      repeat (OVS) @(negedge clk);
      d[i] = link_out;
    end
    repeat (OVS) @(negedge clk);
    bad = link_out;
  endtask

  task automatic put_byte(input logic [DW-1:0] d);
    wr_data  = d;
    pad_i    = d;
    wr_valid = 1'b1;
    do @(negedge clk); while (!wr_ready);
    @(posedge clk); #1;
    wr_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    bit            f_dat, f_bad;
    logic [DW-1:0] f_d;
    int            t0, t1, e0;
    bit            leaked;

    // reset state (R1)
    wait_cycles(5);
    @(negedge clk);
    check(link_out == 1'b0, "R1 link_out low in reset", link_out, 0);
    check(pad_oe == 1'b0,   "R1 pad_oe low in reset", pad_oe, 0);
    tick(); rst = 1'b0;
    @(negedge clk);
    check(link_out == 1'b0, "R1 link_out low after reset", link_out, 0);
    check(rd_valid == 1'b0, "R1 rd_valid low after reset", rd_valid, 0);
    check(wr_ready == 1'b1, "R1 credit held after reset", wr_ready, 1);

    // R2 frame format, R5 hold-off until acknowledge
    tick();
    fork
      put_byte(8'hA5);
      grab(f_dat, f_d, f_bad);
    join
    check(f_dat == 1'b1, "R2 header bits high", f_dat, 1);
    check(f_d == 8'hA5,  "R2 data bits LSB first", f_d, 8'hA5);
    check(f_bad == 1'b0, "R2 stop bit low", f_bad, 0);
    wait_cycles(20);
    @(negedge clk);
    check(wr_ready == 1'b0, "R5 waits for acknowledge", wr_ready, 0);
    tick();
    send_ack();
    wait_cycles(12);
    @(negedge clk);
    check(wr_ready == 1'b1, "R5 credit back after acknowledge", wr_ready, 1);

    // R3 reception at two phases, R4 early acknowledge
    exp_q.push_back(8'h3C);
    fork
      send_frame(8'h3C, 1'b0, 1.3);
      begin
        @(posedge drv_line); t0 = cyc;
        grab(f_dat, f_d, f_bad); t1 = cyc;
      end
    join
    check(f_dat == 1'b0, "R4 acknowledge frame sent", f_dat, 0);
    check((t1 - t0) <= 30, "R4 acknowledge starts early", t1 - t0, 30);
    wait_cycles(10);
    exp_q.push_back(8'hC3);
    fork
      send_frame(8'hC3, 1'b0, 3.1);
      grab(f_dat, f_d, f_bad);
    join
    check(f_dat == 1'b0, "R4 acknowledge for second byte", f_dat, 0);
    wait_cycles(12);
    check(exp_q.size() == 0, "R3 both bytes delivered", exp_q.size(), 0);

    // R7 bad stop bit discards the byte
    e0 = err_seen;
    send_frame(8'h77, 1'b1, 0.5);
    wait_cycles(8);
    @(negedge clk);
    check(rd_valid == 1'b0, "R7 bad frame not presented", rd_valid, 0);
    check(err_seen == e0 + 1, "R7 frame_err pulse", err_seen - e0, 1);
    wait_cycles(30);

    // R8 deferred acknowledge while the buffer is occupied
    rd_take = 1'b0;
    exp_q.push_back(8'h11);
    exp_q.push_back(8'h22);
    fork
      send_frame(8'h11, 1'b0, 2.2);
      grab(f_dat, f_d, f_bad);
    join
    check(f_dat == 1'b0, "R8 first byte acknowledged", f_dat, 0);
    wait_cycles(10);
    @(negedge clk);
    check(rd_valid && rd_data == 8'h11, "R8 first byte waiting", rd_data, 8'h11);
    leaked = 1'b0;
    fork
      send_frame(8'h22, 1'b0, 0.7);
      repeat (60) begin
        @(negedge clk);
        if (link_out) leaked = 1'b1;
      end
    join
    check(leaked == 1'b0, "R8 acknowledge withheld", leaked, 0);
    check(rd_data == 8'h11, "R8 first byte kept", rd_data, 8'h11);
    tick();
    rd_take = 1'b1;
    grab(f_dat, f_d, f_bad);
    check(f_dat == 1'b0, "R8 acknowledge released on read", f_dat, 0);
    wait_cycles(10);
    check(exp_q.size() == 0, "R8 second byte delivered", exp_q.size(), 0);

    // R6 acknowledge goes ahead of a waiting byte
    exp_q.push_back(8'hE1);
    fork
      begin put_byte(8'h5A); put_byte(8'h96); end
      begin #3; send_ack(); send_frame(8'hE1, 1'b0, 0.9); end
      begin
        grab(f_dat, f_d, f_bad);
        check(f_dat && f_d == 8'h5A, "R6 first data frame", f_d, 8'h5A);
        grab(f_dat, f_d, f_bad);
        check(f_dat == 1'b0, "R6 acknowledge before waiting byte", f_dat, 0);
        grab(f_dat, f_d, f_bad);
        check(f_dat && f_d == 8'h96, "R6 waiting byte after", f_d, 8'h96);
      end
    join
    wait_cycles(10);
    send_ack();
    wait_cycles(12);

    // R9 shared port, looped back
    loop_en    = 1'b1;
    bidir_mode = 1'b1;
    dir_out    = 1'b0;
    @(negedge clk);
    check(pad_oe == 1'b0, "R9 pad_oe off when inbound", pad_oe, 0);
    exp_q.push_back(8'h4B);
    tick();
    wr_data  = 8'hFF;
    pad_i    = 8'h4B;
    wr_valid = 1'b1;
    do @(negedge clk); while (!wr_ready);
    @(posedge clk); #1;
    wr_valid = 1'b0;
    wait_cycles(80);
    @(negedge clk);
    check(rd_valid == 1'b0, "R9 byte hidden while inbound", rd_valid, 0);
    check(wr_ready == 1'b1, "R10 credit returned through loop", wr_ready, 1);
    tick();
    dir_out = 1'b1;
    @(negedge clk);
    check(pad_oe == 1'b1,   "R9 pad_oe on when outbound", pad_oe, 1);
    check(pad_o == 8'h4B,   "R9 pad_o carries pad_i byte", pad_o, 8'h4B);
    check(wr_ready == 1'b0, "R9 no writes when outbound", wr_ready, 0);
    wait_cycles(4);

    // R10 stream through loopback in separate-port mode
    bidir_mode = 1'b0;
    dir_out    = 1'b0;
    for (int i = 0; i < 6; i++) begin
      logic [DW-1:0] b;
      b = 8'(i * 37 + 5);
      exp_q.push_back(b);
      put_byte(b);
    end
    wait_cycles(150);
    check(exp_q.size() == 0, "R10 stream delivered in order", exp_q.size(), 0);
    finish_run();
  end
endmodule